// File: doc/BRIEF.md
# Flagged Result Frame Serializer

This block turns one converter result into a 30-bit serial frame. It uses a parallel-in, serial-out shift register. Each frame carries an 8-bit fine code and a 20-bit coarse count. These two fields sit between two constant marker bits: a 1 that leaves first and a 0 that leaves last. A receiver uses the markers to tell whether a complete, correctly aligned frame arrived.

The external communication clock drives the register. While `load_i` is low, every rising edge copies the assembled frame into all stages in parallel. While `load_i` is high, every rising edge moves the contents one stage toward the output end, and the output end drives `serial_o`. Stages are numbered D1 to D30, and D30 is the output end.

The receiver takes the frame as follows. It drops `load_i` for one edge. It then samples `serial_o` just before each of the next 30 shift edges. The first sample is D30, and sample j is D(31-j).

Top module: `flag_frame_piso`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears all 30 stages, so `serial_o` reads 0 after reset until a load occurs.
- R2: A rising edge with `load_i` low captures the frame, and `serial_o` is 1 (stage D30, head marker) right after that edge.
- R3: Stage D1 always captures 0, so sample 30 of a frame (taken after 29 shifts) is 0.
- R4: Stages D2..D9 capture `fine_i`, with `fine_i[k]` in D(2+k). Serial sample j = 29-k therefore carries `fine_i[k]`.
- R5: Stages D10..D29 capture `coarse_i`, with `coarse_i[k]` in D(10+k). Serial sample j = 21-k therefore carries `coarse_i[k]`.
- R6: A rising edge with `load_i` high moves every stage one place toward D30, and D30 leaves first.
- R7: During shifting, stage D1 fills with 0. After 30 or more consecutive shifts, `serial_o` stays 0.
- R8: While `load_i` is high, changes on `fine_i` and `coarse_i` have no effect on the frame being shifted out.
- R9: Back-to-back load edges recapture each time, and the last captured values are the ones serialized.
- R10: Asserting reset in the middle of a frame clears the remaining bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External communication clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | 0: parallel capture, 1: shift one stage per edge |
| fine_i | input | 8 | Fine code from the encoders |
| coarse_i | input | 20 | Coarse count |
| serial_o | output | 1 | Serial frame bit (stage D30) |

## Verification
The bench rebuilds every frame from the serial stream and compares the marker bits and each field bit by bit. A swapped or misaligned field would show as a shifted or mirrored pattern. Three corner cases get directed tests.

- **Inputs change while shifting.** The bench scrambles the inputs during every shift. A design that kept loading would corrupt the trailing bits.
- **Shifting past the frame end.** The bench keeps shifting after the frame. A design that recirculated or filled with 1 would leave a nonzero tail.
- **Reset and double load.** The bench resets mid-frame and loads twice in a row. A synchronous reset or a missed recapture would show up in both.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam logic HEAD_FLAG = 1'b1;
  localparam logic TAIL_FLAG = 1'b0;

  function automatic int frame_len(input int fine_w, input int coarse_w);
    return fine_w + coarse_w + 2;
  endfunction
endpackage

// File: rtl/frame_pack.sv
module frame_pack
  import piso_pkg::*;
#(
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 20,
  localparam int FRAME_W = frame_len(FINE_W, COARSE_W)
) (
  input  logic [FINE_W-1:0]   fine_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic [FRAME_W-1:0]  frame_o
);
  localparam int FINE_LO   = 1;
  localparam int COARSE_LO = FINE_LO + FINE_W;

  // index 0 = D1 (tail), index FRAME_W-1 = D30 (head)
  assign frame_o[0]         = TAIL_FLAG;
  assign frame_o[FRAME_W-1] = HEAD_FLAG;

  for (genvar k = 0; k < FINE_W; k++) begin : g_fine
    assign frame_o[FINE_LO+k] = fine_i[k];
  end

  for (genvar k = 0; k < COARSE_W; k++) begin : g_coarse
    assign frame_o[COARSE_LO+k] = coarse_i[k];
  end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] stage_o
);
  logic [W-1:0] stage_q;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_first
      assign nxt = load_i ? 1'b0 : par_i[0];
    end else begin : g_rest
      assign nxt = load_i ? stage_q[i-1] : par_i[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else         stage_q[i] <= nxt;
    end
  end

  assign stage_o = stage_q;

  p_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> stage_q[W-1:1] == $past(stage_q[W-2:0]));
  p_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !stage_q[0]);
endmodule

// File: rtl/flag_frame_piso.sv
module flag_frame_piso
  import piso_pkg::*;
#(
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 20,
  localparam int FRAME_W = frame_len(FINE_W, COARSE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                serial_o
);
  localparam int CNT_W = $clog2(FRAME_W) + 1;

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] stage_w;

  frame_pack #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_pack (
    .fine_i  (fine_i),
    .coarse_i(coarse_i),
    .frame_o (frame_w)
  );

  shift_chain #(.W(FRAME_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (frame_w),
    .stage_o(stage_w)
  );

  assign serial_o = stage_w[FRAME_W-1];

  // shifts since last load, used by assertions only
  logic [CNT_W-1:0] shift_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          shift_cnt_q <= '0;
    else if (!load_i)                     shift_cnt_q <= '0;
    else if (shift_cnt_q != CNT_W'(FRAME_W)) shift_cnt_q <= shift_cnt_q + 1'b1;
  end

  p_head_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> serial_o);
  p_tail_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_cnt_q == CNT_W'(FRAME_W-1)) |-> !serial_o);
  p_fine_field_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> stage_w[FINE_W:1] == $past(fine_i));
  p_coarse_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> stage_w[FRAME_W-2:FINE_W+1] == $past(coarse_i));
  p_drained_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_cnt_q == CNT_W'(FRAME_W)) |-> !serial_o);
endmodule

// File: tb/sim_flag_frame_piso.sv
module sim_flag_frame_piso;
  localparam int FW = 8;
  localparam int CW = 20;
  localparam int NV = 6;

  localparam logic [FW+CW-1:0] VEC [NV] = '{
    {8'h00, 20'h00000},
    {8'hFF, 20'hFFFFF},
    {8'hA5, 20'h5A5A5},
    {8'h01, 20'h80000},
    {8'h80, 20'h00001},
    {8'h3C, 20'h1234F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b1;
  logic [FW-1:0] fine = '0;
  logic [CW-1:0] coarse = '0;
  logic sout;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flag_frame_piso u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .fine_i(fine), .coarse_i(coarse), .serial_o(sout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // capture on one edge, leave at negedge with load high
  task automatic do_load(input logic [FW-1:0] f, input logic [CW-1:0] c);
    load = 1'b0; fine = f; coarse = c;
    @(negedge clk);
    load = 1'b1;
  endtask

  // sample 30 bits, scrambling inputs meanwhile (R8)
  task automatic take_frame(output logic [29:0] bits);
    for (int j = 1; j <= 30; j++) begin
      bits[30-j] = sout;
      fine = ~fine ^ FW'(j);
      coarse = ~coarse ^ CW'(j * 7);
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic [FW-1:0] f, input logic [CW-1:0] c,
                             input logic [29:0] bits);
    // bits[30-j] holds sample j, i.e. bits[i] = D(i+1)
    logic [FW-1:0] gf;
    logic [CW-1:0] gc;
    gf = bits[FW:1];
    gc = bits[28:FW+1];
    chk("R2 head flag", 32'(bits[29]), 32'd1);
    chk("R3 tail flag", 32'(bits[0]), 32'd0);
    chk("R4 fine field / R8", 32'(gf), 32'(f));
    chk("R5 coarse field / R6 order", 32'(gc), 32'(c));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [29:0] bits;
    @(negedge clk);
    chk("R1 reset output", 32'(sout), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after reset no load", 32'(sout), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [FW-1:0] f;
      logic [CW-1:0] c;
      {f, c} = VEC[v];
      do_load(f, c);
      take_frame(bits);
      check_frame(f, c, bits);
      chk("R7 drained after 30 shifts", 32'(sout), 32'd0);
    end

    // R7: keep shifting well past the frame
    do_load(8'hFF, 20'hFFFFF);
    repeat (40) @(negedge clk);
    chk("R7 zero fill long shift", 32'(sout), 32'd0);

    // R9: two load edges, last wins
    load = 1'b0; fine = 8'h11; coarse = 20'h22222;
    @(negedge clk);
    fine = 8'hC3; coarse = 20'hABCDE;
    @(negedge clk);
    load = 1'b1;
    begin
      logic [FW-1:0] f9;
      logic [CW-1:0] c9;
      f9 = 8'hC3; c9 = 20'hABCDE;
      take_frame(bits);
      chk("R9 last load fine", 32'(bits[FW:1]), 32'(f9));
      chk("R9 last load coarse", 32'(bits[28:FW+1]), 32'(c9));
    end

    // R10: reset mid-frame
    do_load(8'hFF, 20'hFFFFF);
    repeat (5) @(negedge clk);
    chk("R6 mid-frame bit is one", 32'(sout), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", 32'(sout), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 stays clear", 32'(sout), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule